// File: doc/BRIEF.md
# External Bus Write Sequencer

This block carries out write cycles on an external parallel bus that has no clock handshake. A requester inside the chip presents an address, a zone number, a 32-bit data word and a width flag, and holds its request until the sequencer acknowledges it. The sequencer drives a free-running output bus clock, one active-low chip select per zone, an active-low write strobe, an address bus and a 16-bit data bus.

Each bus access has three phases: setup, strobe and hold. Their lengths are counted in timing ticks. A timing tick is `TIM_DIV` system clocks long, and the output bus clock period is `BUS_RATIO` timing ticks. Every access starts on a rising edge of the bus clock. A wide (32-bit) request is sent as two 16-bit accesses. If the first access does not end on a bus-clock period boundary, the chip selects go high for alignment ticks before the second access starts. If it does end on a boundary, the chip select stays low and only the write strobe returns high between the two accesses.

Top module: `ebus_wr_seq`

## Requirements
- R1: After reset, every chip select is high, the write strobe is high and `ack` is low.
- R2: The write strobe stays high for the first `max(cfg_lead,1)` ticks after chip select falls, so a setup value of 0 gives one tick. The strobe never falls in the same cycle that a chip select falls.
- R3: The write strobe is low for `cfg_active+1` ticks per access. Address and data do not change while it is low.
- R4: A chip select stays low for `cfg_trail` ticks after the strobe rises. Each access therefore holds chip select low for `max(cfg_lead,1)+cfg_active+1+cfg_trail` ticks.
- R5: The bus clock is high for the first `BUS_RATIO/2` ticks of each period. Every chip-select falling edge coincides with a rising edge of the bus clock.
- R6: If a wide request's first access is not a whole number of bus-clock periods long, all chip selects go high until the next bus-clock rising edge, and the second access then starts on that edge.
- R7: If the first access is a whole number of periods long, the second access starts at once. The chip select stays low across both accesses and the strobe rises and falls once more, giving exactly two strobe pulses.
- R8: A wide request writes `req_data[15:0]` at `req_addr` first and then `req_data[31:16]` at `req_addr+1`. A narrow request (`req_wide`=0) makes a single access with `req_data[15:0]` at `req_addr`.
- R9: `ack` is high for exactly one system clock per request, in the first cycle after the last access ends, and all chip selects are high in that cycle.
- R10: A request is taken only while the sequencer is idle and `ack` is low. Changes to the request fields during a transfer have no effect, and a request still held high in the `ack` cycle does not start another transfer.
- R11: Only the chip select at index `req_zone` goes low. A zone value of `NZONE` or above drives no chip select low, while the strobe still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_lead | input | LEAD_W | Setup ticks (0 is treated as 1) |
| cfg_active | input | ACT_W | Extra strobe ticks beyond one |
| cfg_trail | input | TRAIL_W | Hold ticks after the strobe |
| req | input | 1 | Request, held until `ack` |
| req_wide | input | 1 | 1: 32-bit write split in two, 0: 16-bit write |
| req_zone | input | ZONE_W | Target zone |
| req_addr | input | ADDR_W | Base half-word address |
| req_data | input | 2*HW_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| bus_clk | output | 1 | Output bus clock |
| bus_cs_n | output | NZONE | Active-low chip selects |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_data | output | HW_W | Bus data |

## Verification
The end of a transfer's last access and the arrival of the next request can land in the same cycle. The sequencer goes idle in the same edge that raises `ack`, so a requester that is slow to drop `req` still has it asserted while the sequencer is already idle. The bench provokes this on every request by keeping `req` high through the `ack` cycle. It then watches a long idle window and requires exactly one `ack` and the expected number of chip-select and strobe edges, so a second, phantom transfer would be counted.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALIGN,
      ST_LEAD,
      ST_ACT,
      ST_TRAIL
   } ebw_state_e;
endpackage

// File: rtl/ebw_tick.sv
module ebw_tick #(
   parameter int TIM_DIV   = 2,
   parameter int BUS_RATIO = 2
) (
   input  logic clk,
   input  logic rst,
   output logic tk,
   output logic tph_last,
   output logic bclk
);
   localparam int TPH_W = $clog2(BUS_RATIO);
   localparam int TD_W  = (TIM_DIV > 1) ? $clog2(TIM_DIV) : 1;

   logic [TPH_W-1:0] tph;

   generate
      if (TIM_DIV == 1) begin : g_nodiv
         assign tk = 1'b1;
      end else begin : g_div
         logic [TD_W-1:0] tdiv;
         always_ff @(posedge clk) begin
            if (rst)                                tdiv <= '0;
            else if (tdiv == TD_W'(TIM_DIV - 1))    tdiv <= '0;
            else                                    tdiv <= tdiv + 1'b1;
         end
         assign tk = (tdiv == TD_W'(TIM_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)           tph <= '0;
      else if (tk)       tph <= tph_last ? '0 : tph + 1'b1;
   end

   assign tph_last = (tph == TPH_W'(BUS_RATIO - 1));
   assign bclk     = (tph < TPH_W'(BUS_RATIO / 2));
endmodule

// File: rtl/ebw_fsm.sv
module ebw_fsm import ebw_pkg::*; #(
   parameter int LEAD_W  = 3,
   parameter int ACT_W   = 3,
   parameter int TRAIL_W = 3,
   parameter int ZONE_W  = 2,
   parameter int ADDR_W  = 19,
   parameter int HW_W    = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                tk,
   input  logic                tph_last,
   input  logic [LEAD_W-1:0]   cfg_lead,
   input  logic [ACT_W-1:0]    cfg_active,
   input  logic [TRAIL_W-1:0]  cfg_trail,
   input  logic                req,
   input  logic                req_wide,
   input  logic [ZONE_W-1:0]   req_zone,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [2*HW_W-1:0]   req_data,
   output logic                ack,
   output logic                acc_on,
   output logic                we_n,
   output logic [ZONE_W-1:0]   zone_q,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [HW_W-1:0]     bus_data
);
   localparam int CNT_W0 = (LEAD_W > ACT_W) ? LEAD_W : ACT_W;
   localparam int CNT_W  = (CNT_W0 > TRAIL_W) ? CNT_W0 : TRAIL_W;

   ebw_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  lead_ld;
   logic              hi_q, wide_q;
   logic [ADDR_W-1:0] addr_q;
   logic [2*HW_W-1:0] data_q;
   logic              acc_end;

   always_comb begin
      lead_ld = (cfg_lead == '0) ? '0 : CNT_W'(cfg_lead - 1'b1);
      acc_end = tk && (cnt == '0) &&
                (((st == ST_ACT) && (cfg_trail == '0)) || (st == ST_TRAIL));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         hi_q   <= 1'b0;
         wide_q <= 1'b0;
         zone_q <= '0;
         addr_q <= '0;
         data_q <= '0;
         ack    <= 1'b0;
      end else begin
         ack <= 1'b0;
         if (acc_end) begin
            if (wide_q && !hi_q) begin
               hi_q <= 1'b1;
               if (tph_last) begin
                  st  <= ST_LEAD;
                  cnt <= lead_ld;
               end else begin
                  st  <= ST_ALIGN;
               end
            end else begin
               st  <= ST_IDLE;
               ack <= 1'b1;
            end
         end else begin
            case (st)
               ST_IDLE: if (req && !ack) begin
                  wide_q <= req_wide;
                  zone_q <= req_zone;
                  addr_q <= req_addr;
                  data_q <= req_data;
                  hi_q   <= 1'b0;
                  st     <= ST_ALIGN;
               end
               ST_ALIGN: if (tk && tph_last) begin
                  st  <= ST_LEAD;
                  cnt <= lead_ld;
               end
               ST_LEAD: if (tk) begin
                  if (cnt == '0) begin
                     st  <= ST_ACT;
                     cnt <= CNT_W'(cfg_active);
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               ST_ACT: if (tk) begin
                  if (cnt == '0) begin
                     st  <= ST_TRAIL;
                     cnt <= CNT_W'(cfg_trail) - 1'b1;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               ST_TRAIL: if (tk) cnt <= cnt - 1'b1;
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign acc_on   = (st == ST_LEAD) || (st == ST_ACT) || (st == ST_TRAIL);
   assign we_n     = (st != ST_ACT);
   assign bus_addr = addr_q + ADDR_W'(hi_q);
   assign bus_data = hi_q ? data_q[2*HW_W-1:HW_W] : data_q[HW_W-1:0];
endmodule

// File: rtl/ebw_csdec.sv
module ebw_csdec #(
   parameter int NZONE  = 3,
   parameter int ZONE_W = 2
) (
   input  logic              en,
   input  logic [ZONE_W-1:0] zone,
   output logic [NZONE-1:0]  cs_n
);
   generate
      for (genvar g = 0; g < NZONE; g++) begin : g_cs
         assign cs_n[g] = !(en && (zone == ZONE_W'(g)));
      end
   endgenerate
endmodule

// File: rtl/ebus_wr_seq.sv
module ebus_wr_seq #(
   parameter int TIM_DIV   = 2,
   parameter int BUS_RATIO = 2,
   parameter int NZONE     = 3,
   parameter int ZONE_W    = 2,
   parameter int ADDR_W    = 19,
   parameter int HW_W      = 16,
   parameter int LEAD_W    = 3,
   parameter int ACT_W     = 3,
   parameter int TRAIL_W   = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [LEAD_W-1:0]   cfg_lead,
   input  logic [ACT_W-1:0]    cfg_active,
   input  logic [TRAIL_W-1:0]  cfg_trail,
   input  logic                req,
   input  logic                req_wide,
   input  logic [ZONE_W-1:0]   req_zone,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [2*HW_W-1:0]   req_data,
   output logic                ack,
   output logic                bus_clk,
   output logic [NZONE-1:0]    bus_cs_n,
   output logic                bus_we_n,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [HW_W-1:0]     bus_data
);
   generate
      if (TIM_DIV < 1)              begin : g_bad_td  $error("TIM_DIV must be at least 1");          end
      if (BUS_RATIO < 2)            begin : g_bad_br  $error("BUS_RATIO must be at least 2");        end
      if (NZONE > (1 << ZONE_W))    begin : g_bad_nz  $error("ZONE_W too narrow for NZONE");         end
      if (LEAD_W < 1 || ACT_W < 1 || TRAIL_W < 1) begin : g_bad_w $error("phase fields need a bit"); end
   endgenerate

   logic              tk, tph_last, acc_on;
   logic [ZONE_W-1:0] zone_q;

   ebw_tick #(.TIM_DIV(TIM_DIV), .BUS_RATIO(BUS_RATIO)) u_tick (
      .clk(clk), .rst(rst), .tk(tk), .tph_last(tph_last), .bclk(bus_clk)
   );

   ebw_fsm #(
      .LEAD_W(LEAD_W), .ACT_W(ACT_W), .TRAIL_W(TRAIL_W),
      .ZONE_W(ZONE_W), .ADDR_W(ADDR_W), .HW_W(HW_W)
   ) u_fsm (
      .clk(clk), .rst(rst), .tk(tk), .tph_last(tph_last),
      .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
      .req(req), .req_wide(req_wide), .req_zone(req_zone),
      .req_addr(req_addr), .req_data(req_data),
      .ack(ack), .acc_on(acc_on), .we_n(bus_we_n), .zone_q(zone_q),
      .bus_addr(bus_addr), .bus_data(bus_data)
   );

   ebw_csdec #(.NZONE(NZONE), .ZONE_W(ZONE_W)) u_cs (
      .en(acc_on), .zone(zone_q), .cs_n(bus_cs_n)
   );
endmodule

// File: rtl/ebw_chk.sv
module ebw_chk #(
   parameter int NZONE  = 3,
   parameter int ADDR_W = 19,
   parameter int HW_W   = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              ack,
   input logic              bus_clk,
   input logic [NZONE-1:0]  bus_cs_n,
   input logic              bus_we_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [HW_W-1:0]   bus_data
);
   a_r2_we_not_with_cs_fall: assert property (@(posedge clk) disable iff (rst)
      (&$past(bus_cs_n) && !(&bus_cs_n)) |-> bus_we_n);

   a_r2_we_fall_cs_steady: assert property (@(posedge clk) disable iff (rst)
      $fell(bus_we_n) |-> $stable(bus_cs_n));

   a_r3_stable_under_we: assert property (@(posedge clk) disable iff (rst)
      (!bus_we_n && !$past(bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_data)));

   a_r5_start_on_rise: assert property (@(posedge clk) disable iff (rst)
      (&$past(bus_cs_n) && !(&bus_cs_n)) |-> (bus_clk && !$past(bus_clk)));

   a_r9_ack_cs_idle: assert property (@(posedge clk) disable iff (rst)
      ack |-> &bus_cs_n);

   a_r9_ack_single: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack);

   a_r11_one_cs: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~bus_cs_n));
endmodule

bind ebus_wr_seq ebw_chk #(.NZONE(NZONE), .ADDR_W(ADDR_W), .HW_W(HW_W)) u_chk (
   .clk(clk), .rst(rst), .ack(ack), .bus_clk(bus_clk), .bus_cs_n(bus_cs_n),
   .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_data(bus_data)
);

// File: tb/sim_ebus_wr_seq.sv
`timescale 1ns/1ps
module sim_ebus_wr_seq;
   localparam int TD = 2, BR = 2, NZ = 3, AW = 19;

   logic clk = 1'b0, rst = 1'b1;
   logic [2:0] cfg_lead = '0, cfg_active = '0, cfg_trail = '0;
   logic req = 1'b0, req_wide = 1'b0;
   logic [1:0] req_zone = '0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_data = '0;
   logic ack, bus_clk, bus_we_n;
   logic [NZ-1:0] bus_cs_n;
   logic [AW-1:0] bus_addr;
   logic [15:0] bus_data;

   always #2.5 clk = ~clk;

   ebus_wr_seq u0 (
      .clk(clk), .rst(rst), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
      .cfg_trail(cfg_trail), .req(req), .req_wide(req_wide), .req_zone(req_zone),
      .req_addr(req_addr), .req_data(req_data), .ack(ack), .bus_clk(bus_clk),
      .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_data(bus_data)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // fields: lead[11:9] active[8:6] trail[5:3] wide[2] zone[1:0]
   localparam logic [11:0] VEC [8] = '{
      {3'd1, 3'd0, 3'd0, 1'b1, 2'd0},
      {3'd1, 3'd0, 3'd1, 1'b1, 2'd1},
      {3'd0, 3'd0, 3'd0, 1'b1, 2'd2},
      {3'd2, 3'd1, 3'd1, 1'b0, 2'd0},
      {3'd3, 3'd2, 3'd0, 1'b1, 2'd1},
      {3'd2, 3'd0, 3'd2, 1'b1, 2'd2},
      {3'd1, 3'd3, 3'd3, 1'b0, 2'd1},
      {3'd4, 3'd1, 3'd2, 1'b1, 2'd3}
   };

   // monitor
   int cyc = 0;
   int m_csfall, m_cslow, m_wefall, m_welow, m_unst, m_ack, m_ackcs, m_other, m_badrise;
   int t_csfall, t_wefall;
   int t_zone;
   logic [AW-1:0] cap_a [2];
   logic [15:0]   cap_d [2];
   logic [NZ-1:0] p_cs = '1;
   logic p_we = 1'b1, p_bclk = 1'b1;
   logic [AW-1:0] p_a = '0;
   logic [15:0] p_d = '0;

   task automatic clr_mon();
      m_csfall = 0; m_cslow = 0; m_wefall = 0; m_welow = 0; m_unst = 0;
      m_ack = 0; m_ackcs = 0; m_other = 0; m_badrise = 0;
      t_csfall = 0; t_wefall = 0;
      cap_a[0] = '0; cap_a[1] = '0; cap_d[0] = '0; cap_d[1] = '0;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         if (&p_cs && !(&bus_cs_n)) begin
            if (!(bus_clk && !p_bclk)) m_badrise++;
            if (m_csfall == 0) t_csfall = cyc;
            m_csfall++;
         end
         if (!(&bus_cs_n)) m_cslow++;
         for (int j = 0; j < NZ; j++)
            if (!bus_cs_n[j] && j != t_zone) m_other++;
         if (p_we && !bus_we_n) begin
            if (m_wefall < 2) begin
               cap_a[m_wefall] = bus_addr;
               cap_d[m_wefall] = bus_data;
            end
            if (m_wefall == 0) t_wefall = cyc;
            m_wefall++;
         end
         if (!bus_we_n) begin
            m_welow++;
            if (!p_we && (bus_addr != p_a || bus_data != p_d)) m_unst++;
         end
         if (ack) begin
            m_ack++;
            if (!(&bus_cs_n)) m_ackcs++;
         end
      end
      p_cs = bus_cs_n; p_we = bus_we_n; p_bclk = bus_clk; p_a = bus_addr; p_d = bus_data;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // issue one request; req held through the ack cycle (R10 corner)
   task automatic do_req(input logic [2:0] l, input logic [2:0] a, input logic [2:0] t,
                         input logic w, input logic [1:0] z, input logic [AW-1:0] ad,
                         input logic [31:0] d, input bit disturb);
      int k;
      clr_mon();
      t_zone = int'(z);
      @(negedge clk);
      cfg_lead = l; cfg_active = a; cfg_trail = t;
      req_wide = w; req_zone = z; req_addr = ad; req_data = d; req = 1'b1;
      k = 0;
      while (!ack && k < 3000) begin
         @(negedge clk);
         k++;
         if (disturb && k == 4) begin
            req_addr = ~ad; req_data = ~d; req_zone = z + 2'd1; req_wide = ~w;
         end
      end
      if (k >= 3000) chk(1'b0, "R9 ack timeout", k, 0);
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      repeat (40) @(negedge clk);
   endtask

   task automatic judge(input logic [2:0] l, input logic [2:0] a, input logic [2:0] t,
                        input logic w, input logic [1:0] z, input logic [AW-1:0] ad,
                        input logic [31:0] d, input string tag);
      int le, n, hv, csf;
      bit merged, zv;
      le = (l == 0) ? 1 : int'(l);
      n  = le + int'(a) + 1 + int'(t);
      hv = w ? 2 : 1;
      merged = w && (n % BR == 0);
      zv = int'(z) < NZ;
      csf = zv ? (merged ? 1 : hv) : 0;
      chk(m_cslow == (zv ? hv * n * TD : 0), {tag, " R4 cs low cycles"}, m_cslow, zv ? hv * n * TD : 0);
      chk(m_welow == hv * (int'(a) + 1) * TD, {tag, " R3 we low cycles"}, m_welow, hv * (int'(a) + 1) * TD);
      chk(m_unst == 0, {tag, " R3 bus stable under we"}, m_unst, 0);
      if (zv) chk(t_wefall - t_csfall == le * TD, {tag, " R2 lead cycles"}, t_wefall - t_csfall, le * TD);
      chk(m_badrise == 0, {tag, " R5 start on bus clock rise"}, m_badrise, 0);
      if (merged) chk(m_csfall == csf, {tag, " R7 cs kept low"}, m_csfall, csf);
      else        chk(m_csfall == csf, {tag, " R6 cs falls"}, m_csfall, csf);
      chk(m_wefall == hv, {tag, " R7 we pulses"}, m_wefall, hv);
      chk(cap_a[0] == ad && cap_d[0] == d[15:0], {tag, " R8 low half"}, int'(cap_d[0]), int'(d[15:0]));
      if (w) chk(cap_a[1] == AW'(ad + 1) && cap_d[1] == d[31:16], {tag, " R8 high half"},
                 int'(cap_d[1]), int'(d[31:16]));
      chk(m_ack == 1, {tag, " R9 ack count"}, m_ack, 1);
      chk(m_ackcs == 0, {tag, " R9 cs high at ack"}, m_ackcs, 0);
      chk(m_other == 0, {tag, " R11 other zones"}, m_other, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_zone = 0;
      clr_mon();
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(&bus_cs_n, "R1 cs after reset", int'(bus_cs_n), 7);
      chk(bus_we_n == 1'b1, "R1 we after reset", int'(bus_we_n), 1);
      chk(ack == 1'b0, "R1 ack after reset", int'(ack), 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         logic [11:0] v;
         logic [AW-1:0] ad;
         logic [31:0] d;
         v  = VEC[i];
         ad = AW'(19'h00120 + 19'h00333 * i);
         d  = {16'h5A00 + 16'(i), 16'hC300 + 16'(i * 7)};
         do_req(v[11:9], v[8:6], v[5:3], v[2], v[1:0], ad, d, 1'b0);
         judge(v[11:9], v[8:6], v[5:3], v[2], v[1:0], ad, d, $sformatf("vec%0d", i));
      end

      // R10: request fields change while busy
      do_req(3'd1, 3'd1, 3'd1, 1'b1, 2'd1, 19'h7FFFF, 32'hBEEF_1234, 1'b1);
      judge(3'd1, 3'd1, 3'd1, 1'b1, 2'd1, 19'h7FFFF, 32'hBEEF_1234, "R10 busy change");

      // R2 corner: setup 0 with long strobe on narrow write, R11 zone 2
      do_req(3'd0, 3'd4, 3'd0, 1'b0, 2'd2, 19'h00010, 32'h0000_8001, 1'b0);
      judge(3'd0, 3'd4, 3'd0, 1'b0, 2'd2, 19'h00010, 32'h0000_8001, "R2 zero setup");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule